// File: doc/BRIEF.md
# Prioritized UART interrupt identification

This block sits in the register slice of a 16550-compatible serial port. It decides which pending condition the port reports to software and drives the single interrupt request line. Four sources compete for the report. They are, in order: a sticky overrun flag, a non-empty receive buffer, a transmit-ready pending flag, and a modem-change flag. Each source is gated by its own bit of an enable register, and the block owns that register.

Software reads three registers through the block. The identification register holds the winning code, with two FIFO indicator bits on top. The enable register reads back what was written, masked. The line status register holds data-ready, the overrun flag and two transmitter bits that are always set.

Some reads and writes change state. A write to the data offset marks the transmitter as having room again. Reading the identification register while it reports the transmit source clears that flag. Reading line status clears the overrun flag. The surrounding port supplies the receive-buffer state, overrun events, the modem-change flag and the FIFO mode.

Top module: `uart_irq_ident`

## Requirements
- R1: After a synchronous reset, the enable register, the overrun flag and the transmit pending flag are all 0. With these at 0, irq is low and the identification register reads 0x01.
- R2: A write to offset 1 stores only bits 3:0 of the data. A read of offset 1 returns those bits, with bits 7:4 reading 0.
- R3: The identification register (read at offset 2) has its low nibble set by the highest active gated source. The codes are, from highest to lowest priority:
  - overrun with enable bit 2: 0x6
  - receive non-empty with enable bit 0: 0xC
  - transmit pending with enable bit 1: 0x2
  - modem change with enable bit 3: 0x0
  - none of these: 0x1
- R4: When the receive buffer is non-empty, the low nibble reports the timeout code 0xC, never the plain data-available code 0x4.
- R5: Every write to offset 0 sets the transmit pending flag. A read of offset 2 clears the flag only when that read reports code 0x2. A read that reports a higher-priority source leaves the flag set.
- R6: Bits 7:6 of the identification value are both 1 when fifo_en is high and both 0 when it is low. Bits 5:4 are always 0.
- R7: irq is high exactly when the current reason is not 0x1. It follows any register access or input change in the same cycle that the state or input changes.
- R8: An ovr_evt pulse sets the overrun flag from the next cycle. A read of offset 5 clears the flag unless ovr_evt is high in that same cycle, in which case the flag stays set.
- R9: A read of offset 5 returns bit 0 = rx_nonempty, bit 1 = overrun flag, bits 5 and 6 = 1, and all other bits 0.
- R10: rd_data is 0x00 when reg_rd is low, and also for a read of any offset other than 1, 2 or 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe, one cycle per access; read side effects occur at the closing edge |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid in the cycle of reg_rd |
| ovr_evt | input | 1 | One-cycle pulse: the receive buffer lost a character |
| rx_nonempty | input | 1 | Receive buffer holds at least one character |
| modem_chg | input | 1 | Any modem status delta bit is set |
| fifo_en | input | 1 | FIFO mode is enabled |
| irq | output | 1 | Interrupt request, active high |

## Verification
rd_data and irq are combinational from the registered state and the current inputs. A read therefore returns its value in the same cycle as its strobe. Any side effect of an access or an ovr_evt pulse first shows in the cycle after the closing edge.

The bench drives each access at the falling edge and compares one time unit later, still inside that cycle, against a behavioural model. It then moves the model's state forward at the rising edge. The directed checks make use of this: a flag-clearing read is followed by a second read in the next cycle, and that second read is where the effect is checked.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    // Register offsets decoded by software; positions are fixed by the port's map.
    localparam int unsigned ADDR_W    = 3;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned EN_W      = 4;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_EN    = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_IDENT = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_LINE  = 3'd5;

    // Source indices, listed in falling priority.
    localparam int unsigned NSRC      = 4;
    localparam int unsigned SRC_OVR   = 0;
    localparam int unsigned SRC_RX    = 1;
    localparam int unsigned SRC_TX    = 2;
    localparam int unsigned SRC_MODEM = 3;

    // Enable-register bit for each source.
    localparam int unsigned EN_RX     = 0;
    localparam int unsigned EN_TX     = 1;
    localparam int unsigned EN_OVR    = 2;
    localparam int unsigned EN_MODEM  = 3;

    typedef enum logic [3:0] {
        CODE_MODEM = 4'h0,
        CODE_NONE  = 4'h1,
        CODE_TX    = 4'h2,
        CODE_OVR   = 4'h6,
        CODE_RXTO  = 4'hC
    } reason_e;

    // Maps a source index to its reported code.
    function automatic reason_e src_code(input int unsigned idx);
        case (idx)
            SRC_OVR: return CODE_OVR;
            SRC_RX:  return CODE_RXTO;
            SRC_TX:  return CODE_TX;
            default: return CODE_MODEM;
        endcase
    endfunction
endpackage

// File: rtl/uirq_enable_reg.sv
// Enable register: holds the per-source interrupt enables.
// Assumes: wr_en is a single-cycle strobe; bits at and above EN_W are forced to 0.
module uirq_enable_reg #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned EN_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] en_q
);
    localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'((1 << EN_W) - 1);

    // Capture the masked enable bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wdata & KEEP_MASK;
    end
endmodule

// File: rtl/uirq_line_status.sv
// Line status: sticky overrun flag plus the assembled status byte.
// Assumes: the transmitter is modelled as always idle, so its two bits read 1.
module uirq_line_status #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovr_evt,
    input  logic              rd_clr,
    input  logic              rx_nonempty,
    output logic              ovr_q,
    output logic [DATA_W-1:0] status
);
    localparam int unsigned BIT_DR   = 0;
    localparam int unsigned BIT_OVR  = 1;
    localparam int unsigned BIT_THR  = 5;
    localparam int unsigned BIT_IDLE = 6;

    // A new event outranks a clearing read in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovr_q <= 1'b0;
        else if (ovr_evt) ovr_q <= 1'b1;
        else if (rd_clr)  ovr_q <= 1'b0;
    end

    // Assemble the status byte from live state.
    always_comb begin
        status           = '0;
        status[BIT_DR]   = rx_nonempty;
        status[BIT_OVR]  = ovr_q;
        status[BIT_THR]  = 1'b1;
        status[BIT_IDLE] = 1'b1;
    end
endmodule

// File: rtl/uirq_tx_pending.sv
// Transmit-ready pending flag: set by data writes, cleared by an acknowledging read.
// Assumes: set and clear never come in the same cycle (one address per access).
module uirq_tx_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_q
);
    // Set wins over clear should both ever coincide.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (set_i) pend_q <= 1'b1;
        else if (clr_i) pend_q <= 1'b0;
    end
endmodule

// File: rtl/uirq_prio.sv
// Priority selector: picks the highest gated request and builds the identification byte.
// Assumes: req index 0 is the highest priority.
module uirq_prio
    import uirq_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned N      = NSRC
) (
    input  logic [N-1:0]      req,
    input  logic              fifo_on,
    output reason_e           reason,
    output logic [DATA_W-1:0] ident
);
    localparam int unsigned CODE_W = 4;

    // Scan from lowest to highest priority so the highest active request wins.
    always_comb begin
        reason = CODE_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) reason = src_code(i);
        end
    end

    // Place the reason code and the FIFO indicator bits.
    always_comb begin
        ident              = '0;
        ident[CODE_W-1:0]  = reason;
        ident[DATA_W-1]    = fifo_on;
        ident[DATA_W-2]    = fifo_on;
    end
endmodule

// File: rtl/uart_irq_ident.sv
// Interrupt identification slice of a 16550-style port.
// Decodes register accesses, gates four sources by their enables, reports the winner
// and drives irq. Assumes reg_wr and reg_rd are never high together.
module uart_irq_ident
    import uirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ovr_evt,
    input  logic              rx_nonempty,
    input  logic              modem_chg,
    input  logic              fifo_en,
    output logic              irq
);
    logic [DATA_W-1:0] en_q;
    logic [DATA_W-1:0] line_byte;
    logic [DATA_W-1:0] ident_byte;
    logic [NSRC-1:0]   req;
    logic              ovr_q;
    logic              tx_pend;
    reason_e           reason;

    logic wr_data, wr_en, rd_ident, rd_line, rd_en;

    // Address decode of the four offsets this slice owns.
    always_comb begin
        wr_data  = reg_wr && (reg_addr == OFS_DATA);
        wr_en    = reg_wr && (reg_addr == OFS_EN);
        rd_ident = reg_rd && (reg_addr == OFS_IDENT);
        rd_line  = reg_rd && (reg_addr == OFS_LINE);
        rd_en    = reg_rd && (reg_addr == OFS_EN);
    end

    uirq_enable_reg #(.DATA_W(DATA_W), .EN_W(EN_W)) u_en (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(reg_wdata), .en_q(en_q)
    );

    uirq_line_status #(.DATA_W(DATA_W)) u_line (
        .clk(clk), .rst_n(rst_n), .ovr_evt(ovr_evt), .rd_clr(rd_line),
        .rx_nonempty(rx_nonempty), .ovr_q(ovr_q), .status(line_byte)
    );

    uirq_tx_pending u_tx (
        .clk(clk), .rst_n(rst_n), .set_i(wr_data),
        .clr_i(rd_ident && (reason == CODE_TX)), .pend_q(tx_pend)
    );

    // Gate each raw source by its enable bit.
    always_comb begin
        req            = '0;
        req[SRC_OVR]   = ovr_q       && en_q[EN_OVR];
        req[SRC_RX]    = rx_nonempty && en_q[EN_RX];
        req[SRC_TX]    = tx_pend     && en_q[EN_TX];
        req[SRC_MODEM] = modem_chg   && en_q[EN_MODEM];
    end

    uirq_prio #(.DATA_W(DATA_W), .N(NSRC)) u_prio (
        .req(req), .fifo_on(fifo_en), .reason(reason), .ident(ident_byte)
    );

    // The request line follows the current reason.
    assign irq = (reason != CODE_NONE);

    // Read data multiplexer; zero when idle or for offsets owned elsewhere.
    always_comb begin
        rd_data = '0;
        if (rd_en)         rd_data = en_q;
        else if (rd_ident) rd_data = ident_byte;
        else if (rd_line)  rd_data = line_byte;
    end
endmodule

// File: rtl/uirq_checker.sv
// Property checker for uart_irq_ident, attached by bind.
module uirq_checker
    import uirq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              ovr_evt,
    input logic              fifo_en,
    input logic              irq,
    input logic              ovr_q,
    input logic              tx_pend
);
    a_r5_write_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_DATA) |=> tx_pend);

    a_r8_event_sets_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> ovr_q);

    a_r8_read_clears_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_LINE && !ovr_evt) |=> !ovr_q);

    a_r2_enable_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_EN) |-> rd_data[7:4] == 4'h0);

    a_r7_irq_tracks_ident: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_IDENT) |-> irq == (rd_data[3:0] != 4'h1));

    a_r6_fifo_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_IDENT) |-> rd_data[7:4] == {fifo_en, fifo_en, 2'b00});

    a_r9_line_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_LINE) |-> rd_data[6:5] == 2'b11);

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> rd_data == 8'h00);
endmodule

bind uart_irq_ident uirq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .rd_data(rd_data), .ovr_evt(ovr_evt), .fifo_en(fifo_en), .irq(irq),
    .ovr_q(ovr_q), .tx_pend(tx_pend)
);

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] rd_data;
    logic       ovr_evt = 1'b0, rx_nonempty = 1'b0, modem_chg = 1'b0, fifo_en = 1'b0;
    logic       irq;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // Behavioural reference state.
    int m_en = 0, m_ovr = 0, m_pend = 0;
    logic [7:0] last_rd;

    always #4 clk = ~clk;

    uart_irq_ident uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_data(rd_data), .ovr_evt(ovr_evt),
        .rx_nonempty(rx_nonempty), .modem_chg(modem_chg), .fifo_en(fifo_en), .irq(irq)
    );

    function automatic int model_reason();
        if (m_ovr != 0 && m_en[2]) return 'h6;
        if (rx_nonempty && m_en[0]) return 'hC;
        if (m_pend != 0 && m_en[1]) return 'h2;
        if (modem_chg && m_en[3]) return 'h0;
        return 'h1;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // One bus cycle: drive at falling edge, compare, advance model at rising edge.
    task automatic step(input bit w, input bit r, input logic [2:0] a, input logic [7:0] d);
        int rsn, exp_rd;
        string tag;
        @(negedge clk);
        reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
        #1;
        last_rd = rd_data;
        rsn = model_reason();
        if (rst_n) begin
            exp_rd = 0;
            tag = "R10";
            if (r) begin
                case (a)
                    3'd1: begin exp_rd = m_en; tag = "R2"; end
                    3'd2: begin exp_rd = rsn | (fifo_en ? 'hC0 : 0); tag = "R3"; end
                    3'd5: begin exp_rd = 'h60 | (m_ovr << 1) | int'(rx_nonempty); tag = "R9"; end
                    default: exp_rd = 0;
                endcase
            end
            check(tag, rd_data, exp_rd);
            check("R7", irq, (rsn != 1) ? 1 : 0);
        end
        if (!rst_n) begin
            m_en = 0; m_ovr = 0; m_pend = 0;
        end else begin
            if (w && a == 3'd1) m_en = d & 'h0F;
            if (w && a == 3'd0) m_pend = 1;
            else if (r && a == 3'd2 && rsn == 'h2) m_pend = 0;
            if (ovr_evt) m_ovr = 1;
            else if (r && a == 3'd5) m_ovr = 0;
        end
        @(posedge clk);
        #1;
        reg_wr = 0; reg_rd = 0; ovr_evt = 0;
    endtask

    task automatic rd(input logic [2:0] a); step(0, 1, a, 8'h00); endtask
    task automatic wr(input logic [2:0] a, input logic [7:0] d); step(1, 0, a, d); endtask

    initial begin
        repeat (3) step(0, 0, 3'd0, 8'h00);
        rst_n = 1;
        // R1: reset state
        step(0, 0, 3'd0, 8'h00);
        check("R1", irq, 0);
        rd(3'd2); check("R1", last_rd, 'h01);
        rd(3'd1); check("R1", last_rd, 'h00);

        // R2: mask on enable write
        wr(3'd1, 8'hFF); rd(3'd1); check("R2", last_rd, 'h0F);

        // R4: receive data reports the timeout code
        wr(3'd1, 8'h01); rx_nonempty = 1;
        rd(3'd2); check("R4", last_rd, 'h0C); check("R4", irq, 1);
        rx_nonempty = 0;

        // R5: data write sets pending, acknowledging read clears it
        wr(3'd1, 8'h02); wr(3'd0, 8'h41);
        rd(3'd2); check("R5", last_rd, 'h02);
        rd(3'd2); check("R5", last_rd, 'h01);
        // R5: pending survives a read that reports a higher source
        wr(3'd1, 8'h03); rx_nonempty = 1; wr(3'd0, 8'h42);
        rd(3'd2); check("R5", last_rd, 'h0C);
        rx_nonempty = 0;
        rd(3'd2); check("R5", last_rd, 'h02);

        // R3: full priority walk
        wr(3'd1, 8'h0F); wr(3'd0, 8'h43); ovr_evt = 1; step(0, 0, 3'd0, 8'h00);
        rx_nonempty = 1; modem_chg = 1;
        rd(3'd2); check("R3", last_rd, 'h06);
        rd(3'd5); check("R3", last_rd, 'h63);
        rd(3'd2); check("R3", last_rd, 'h0C);
        rx_nonempty = 0;
        rd(3'd2); check("R3", last_rd, 'h02);
        rd(3'd2); check("R3", last_rd, 'h00);
        modem_chg = 0;
        rd(3'd2); check("R3", last_rd, 'h01); check("R7", irq, 0);

        // R6: FIFO indicator bits
        fifo_en = 1; rd(3'd2); check("R6", last_rd, 'hC1);
        fifo_en = 0;

        // R8: event in the same cycle as a clearing read keeps the flag
        ovr_evt = 1; rd(3'd5); check("R8", last_rd, 'h60);
        rd(3'd5); check("R8", last_rd, 'h62);
        rd(3'd5); check("R8", last_rd, 'h60);

        // R9: data-ready follows the receive buffer
        rx_nonempty = 1; rd(3'd5); check("R9", last_rd, 'h61);
        rx_nonempty = 0;

        // R10: unowned offset reads zero
        rd(3'd3); check("R10", last_rd, 'h00);

        // Random traffic against the model
        for (int i = 0; i < 800; i++) begin
            int op;
            op = $urandom_range(0, 3);
            ovr_evt     = ($urandom_range(0, 7) == 0);
            rx_nonempty = $urandom_range(0, 1) == 1;
            modem_chg   = $urandom_range(0, 1) == 1;
            fifo_en     = $urandom_range(0, 1) == 1;
            step(op == 1, op == 2, 3'($urandom_range(0, 7)), 8'($urandom));
        end

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule